// File: doc/BRIEF.md
# Interrupt Line Servicing Engine

This block watches a set of interrupt input lines and turns their activity into delivery requests. Each line has its own configuration: a mask bit, an active-low select, a trigger mode (edge or level), an interrupt vector and a destination tag. When a line asserts in its configured way, the block raises a single request toward the message fabric. The request carries the pin number, the vector and the destination, and it stays up until the fabric acknowledges it.

Edge-mode lines fire once on each inactive-to-active transition. Level-mode lines fire while they are held active. After a level delivery, a per-line "serviced, awaiting completion" flag blocks further deliveries until an end-of-interrupt (EOI) carrying the matching vector arrives. If the line is still active when that flag clears, the interrupt is injected again. One designated line, the real-time-clock pin, also has a completion flag in edge mode. Its edges are therefore coalesced down to one delivery per EOI. Line levels are sampled every cycle whether or not a line is masked, so unmasking never invents an edge.

Top module: `pin_irq_engine`

## Requirements
- R1: An edge-mode line (level bit 0) issues exactly one request per inactive-to-active transition. Holding it active issues nothing more, and an EOI does not re-arm it. The line must go inactive and then active again before it fires a second time.
- R2: A masked line (mask bit 1) issues no request. An edge that occurs while the line is masked is never delivered later. After the line is unmasked with its level already active, nothing fires until a fresh inactive-to-active transition occurs.
- R3: A level-mode line (level bit 1) that goes active while masked issues its request once it is unmasked, provided it is still active.
- R4: Acknowledging a level-mode request sets that pin's bit in `remoteIrr` on the acknowledging clock edge. While the bit is set, the pin issues no further request.
- R5: An EOI clears the `remoteIrr` bit of every level-mode pin whose vector equals `eoiVector`. Pins with other vectors are unaffected. A pin whose line is still active is then requested again.
- R6: With polarity bit 1 a line is active-low. A low input then counts as asserted, and a high input counts as inactive.
- R7: For the pin at index `RTC_PIN` in edge mode, an acknowledged request sets `rtcIrr`. While `rtcIrr` is set, new edges on that pin are dropped. An EOI whose vector equals that pin's vector clears `rtcIrr`.
- R8: At most one request is outstanding. `reqValid`, `reqPin`, `reqVector` and `reqDest` hold steady until a cycle in which `reqAck` is high. `reqVector` and `reqDest` equal the pin's configured vector and destination.
- R9: When several pins are ready in the same cycle, the lowest-numbered pin is requested first.
- R10: `deliveryPending` has exactly bit `reqPin` set while a request is outstanding. It is all zero otherwise.
- R11: A pin in edge mode holds its `remoteIrr` bit at 0. Switching a serviced level pin to edge mode and back therefore acts as an implicit EOI.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lineIn | input | NUM_PINS | Raw interrupt input lines |
| cfgMask | input | NUM_PINS | Per-pin mask, 1 = masked |
| cfgPolarity | input | NUM_PINS | Per-pin polarity, 1 = active-low |
| cfgLevel | input | NUM_PINS | Per-pin trigger mode, 1 = level, 0 = edge |
| cfgVector | input | NUM_PINS*VEC_W | Per-pin vector, pin i at bits [i*VEC_W +: VEC_W] |
| cfgDest | input | NUM_PINS*DEST_W | Per-pin destination, pin i at bits [i*DEST_W +: DEST_W] |
| eoiValid | input | 1 | End-of-interrupt strobe |
| eoiVector | input | VEC_W | Vector carried by the EOI |
| reqValid | output | 1 | Delivery request outstanding |
| reqPin | output | PIN_W | Pin index of the outstanding request |
| reqVector | output | VEC_W | Vector of the outstanding request |
| reqDest | output | DEST_W | Destination of the outstanding request |
| reqAck | input | 1 | Fabric accepts the outstanding request |
| remoteIrr | output | NUM_PINS | Per-pin level completion flags |
| rtcIrr | output | 1 | Edge completion flag of the real-time-clock pin |
| deliveryPending | output | NUM_PINS | One-hot delivery status of the outstanding request |

## Verification
The bench builds the block with its defaults: 24 pins, 8-bit vectors and destinations, and the real-time-clock pin at index 8. These values let the directed cases reach both the top pin (23) and the bottom pins of the priority chain, and they put the coalescing pin in the middle of the priority order. A randomized phase keeps every pin in level mode and toggles the lines and acknowledges at random. It also sends EOIs drawn from four shared vectors, so that one EOI often clears several pins at once and often coincides with an acknowledge. A bench model of the completion flags is compared against `remoteIrr` on every cycle of this phase.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;
  // Upper bound on the width of a pin index carried in the strobe struct.
  localparam int MAX_PIN_IDX_W = 8;

  // Control -> datapath strobes: a request was accepted by the fabric.
  typedef struct packed {
    logic                     retire;
    logic [MAX_PIN_IDX_W-1:0] pin;
  } svcStrobe_t;
endpackage

// File: rtl/pin_irq_datapath.sv
module pin_irq_datapath
  import pin_irq_pkg::*;
#(
  parameter int NUM_PINS = 24,
  parameter int VEC_W    = 8,
  parameter int RTC_PIN  = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NUM_PINS-1:0]       lineIn,
  input  logic [NUM_PINS-1:0]       cfgMask,
  input  logic [NUM_PINS-1:0]       cfgPolarity,
  input  logic [NUM_PINS-1:0]       cfgLevel,
  input  logic [NUM_PINS*VEC_W-1:0] cfgVector,
  input  logic                      eoiValid,
  input  logic [VEC_W-1:0]          eoiVector,
  input  svcStrobe_t                strobe,
  output logic [NUM_PINS-1:0]       readyVec,
  output logic [NUM_PINS-1:0]       remoteIrr,
  output logic                      rtcIrr
);
  localparam bit HAS_RTC = (RTC_PIN >= 0) && (RTC_PIN < NUM_PINS);

  logic [NUM_PINS-1:0] activeNow;
  logic [NUM_PINS-1:0] activeLast;
  logic [NUM_PINS-1:0] riseSeen;
  logic [NUM_PINS-1:0] edgePend;
  logic [NUM_PINS-1:0] vecMatch;
  logic [NUM_PINS-1:0] retireHot;
  logic [NUM_PINS-1:0] edgeBlock;
  logic                rtcFlag;

  always_comb begin
    for (int i = 0; i < NUM_PINS; i++) begin
      activeNow[i] = lineIn[i] ^ cfgPolarity[i];
      riseSeen[i]  = activeNow[i] & ~activeLast[i];
      vecMatch[i]  = eoiValid && (cfgVector[i*VEC_W +: VEC_W] == eoiVector);
      retireHot[i] = strobe.retire && (int'(strobe.pin) == i);
      edgeBlock[i] = 1'b0;
    end
    if (HAS_RTC) edgeBlock[RTC_PIN] = rtcFlag;
  end

  // Line level is tracked every cycle, masked or not.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      activeLast <= '0;
      edgePend   <= '0;
      remoteIrr  <= '0;
    end else begin
      activeLast <= activeNow;
      for (int i = 0; i < NUM_PINS; i++) begin
        if (cfgLevel[i] || cfgMask[i]) edgePend[i] <= 1'b0;
        else edgePend[i] <= (edgePend[i] & ~retireHot[i]) | (riseSeen[i] & ~edgeBlock[i]);

        if (!cfgLevel[i])      remoteIrr[i] <= 1'b0;
        else if (retireHot[i]) remoteIrr[i] <= 1'b1;
        else if (vecMatch[i])  remoteIrr[i] <= 1'b0;
      end
    end
  end

  generate
    if (HAS_RTC) begin : g_rtc
      always_ff @(posedge clk) begin
        if (!rstN) rtcFlag <= 1'b0;
        else if (cfgLevel[RTC_PIN]) rtcFlag <= 1'b0;
        else if (retireHot[RTC_PIN]) rtcFlag <= 1'b1;
        else if (vecMatch[RTC_PIN]) rtcFlag <= 1'b0;
      end

      // R7
      rtc_flag_set_chk: assert property (@(posedge clk) disable iff (!rstN)
        (retireHot[RTC_PIN] && !cfgLevel[RTC_PIN]) |=> rtcFlag);
    end else begin : g_no_rtc
      assign rtcFlag = 1'b0;
    end
  endgenerate

  assign rtcIrr = rtcFlag;

  always_comb begin
    for (int i = 0; i < NUM_PINS; i++)
      readyVec[i] = ~cfgMask[i] & (cfgLevel[i] ? (activeNow[i] & ~remoteIrr[i]) : edgePend[i]);
  end

  generate
    for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin_chk
      // R4
      irr_set_on_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
        (strobe.retire && int'(strobe.pin) == g && cfgLevel[g]) |=> remoteIrr[g]);
      // R5
      irr_clear_on_eoi_chk: assert property (@(posedge clk) disable iff (!rstN)
        (eoiValid && cfgVector[g*VEC_W +: VEC_W] == eoiVector
         && !(strobe.retire && int'(strobe.pin) == g)) |=> !remoteIrr[g]);
      // R11
      irr_edge_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
        !cfgLevel[g] |=> !remoteIrr[g]);
      // R2
      masked_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
        cfgMask[g] |-> !readyVec[g]);
    end
  endgenerate
endmodule

// File: rtl/pin_irq_ctrl.sv
module pin_irq_ctrl
  import pin_irq_pkg::*;
#(
  parameter int NUM_PINS = 24,
  parameter int VEC_W    = 8,
  parameter int DEST_W   = 8,
  localparam int PIN_W   = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [NUM_PINS-1:0]        readyVec,
  input  logic [NUM_PINS*VEC_W-1:0]  cfgVector,
  input  logic [NUM_PINS*DEST_W-1:0] cfgDest,
  input  logic                       reqAck,
  output logic                       reqValid,
  output logic [PIN_W-1:0]           reqPin,
  output logic [VEC_W-1:0]           reqVector,
  output logic [DEST_W-1:0]          reqDest,
  output svcStrobe_t                 strobe
);
  logic [PIN_W-1:0]    pickIdx;
  logic                anyReady;
  logic [NUM_PINS-1:0] belowMask;

  // Lowest-numbered ready pin wins.
  always_comb begin
    pickIdx  = '0;
    anyReady = |readyVec;
    for (int k = NUM_PINS - 1; k >= 0; k--)
      if (readyVec[k]) pickIdx = PIN_W'(k);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqValid  <= 1'b0;
      reqPin    <= '0;
      reqVector <= '0;
      reqDest   <= '0;
    end else if (!reqValid) begin
      if (anyReady) begin
        reqValid  <= 1'b1;
        reqPin    <= pickIdx;
        reqVector <= cfgVector[int'(pickIdx)*VEC_W +: VEC_W];
        reqDest   <= cfgDest[int'(pickIdx)*DEST_W +: DEST_W];
      end
    end else if (reqAck) begin
      reqValid <= 1'b0;
    end
  end

  always_comb begin
    strobe.retire = reqValid & reqAck;
    strobe.pin    = MAX_PIN_IDX_W'(reqPin);
  end

  always_comb begin
    for (int k = 0; k < NUM_PINS; k++) belowMask[k] = (k < int'(reqPin));
  end

  // R8
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqAck) |=> (reqValid && $stable(reqPin) && $stable(reqVector) && $stable(reqDest)));
  // R9
  lowest_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(reqValid) |-> ((($past(readyVec) & belowMask) == '0)
                         && ((($past(readyVec) >> reqPin) & NUM_PINS'(1)) != '0)));
endmodule

// File: rtl/pin_irq_engine.sv
module pin_irq_engine
  import pin_irq_pkg::*;
#(
  parameter int NUM_PINS = 24,
  parameter int VEC_W    = 8,
  parameter int DEST_W   = 8,
  parameter int RTC_PIN  = 8,
  localparam int PIN_W   = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [NUM_PINS-1:0]        lineIn,
  input  logic [NUM_PINS-1:0]        cfgMask,
  input  logic [NUM_PINS-1:0]        cfgPolarity,
  input  logic [NUM_PINS-1:0]        cfgLevel,
  input  logic [NUM_PINS*VEC_W-1:0]  cfgVector,
  input  logic [NUM_PINS*DEST_W-1:0] cfgDest,
  input  logic                       eoiValid,
  input  logic [VEC_W-1:0]           eoiVector,
  output logic                       reqValid,
  output logic [PIN_W-1:0]           reqPin,
  output logic [VEC_W-1:0]           reqVector,
  output logic [DEST_W-1:0]          reqDest,
  input  logic                       reqAck,
  output logic [NUM_PINS-1:0]        remoteIrr,
  output logic                       rtcIrr,
  output logic [NUM_PINS-1:0]        deliveryPending
);
  logic [NUM_PINS-1:0] readyVec;
  svcStrobe_t          strobe;

  pin_irq_datapath #(
    .NUM_PINS(NUM_PINS), .VEC_W(VEC_W), .RTC_PIN(RTC_PIN)
  ) u_dp (
    .clk(clk), .rstN(rstN), .lineIn(lineIn), .cfgMask(cfgMask),
    .cfgPolarity(cfgPolarity), .cfgLevel(cfgLevel), .cfgVector(cfgVector),
    .eoiValid(eoiValid), .eoiVector(eoiVector), .strobe(strobe),
    .readyVec(readyVec), .remoteIrr(remoteIrr), .rtcIrr(rtcIrr)
  );

  pin_irq_ctrl #(
    .NUM_PINS(NUM_PINS), .VEC_W(VEC_W), .DEST_W(DEST_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .readyVec(readyVec), .cfgVector(cfgVector),
    .cfgDest(cfgDest), .reqAck(reqAck), .reqValid(reqValid), .reqPin(reqPin),
    .reqVector(reqVector), .reqDest(reqDest), .strobe(strobe)
  );

  always_comb begin
    for (int k = 0; k < NUM_PINS; k++)
      deliveryPending[k] = reqValid && (int'(reqPin) == k);
  end

  // R10
  status_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones(deliveryPending) == (reqValid ? 1 : 0));
endmodule

// File: tb/pin_irq_engine_test.sv
module pin_irq_engine_test;
  localparam int NP = 24;
  localparam int VW = 8;
  localparam int DW = 8;
  localparam int PW = 5;

  logic          clk = 1'b0;
  logic          rstN;
  logic [NP-1:0] lineIn, cfgMask, cfgPolarity, cfgLevel;
  logic [NP*VW-1:0] cfgVector;
  logic [NP*DW-1:0] cfgDest;
  logic          eoiValid;
  logic [VW-1:0] eoiVector;
  logic          reqValid, reqAck, rtcIrr;
  logic [PW-1:0] reqPin;
  logic [VW-1:0] reqVector;
  logic [DW-1:0] reqDest;
  logic [NP-1:0] remoteIrr, deliveryPending;

  int checks = 0;
  int fails  = 0;
  bit summaryDone = 0;

  always #2 clk = ~clk;

  pin_irq_engine uut (
    .clk(clk), .rstN(rstN), .lineIn(lineIn), .cfgMask(cfgMask),
    .cfgPolarity(cfgPolarity), .cfgLevel(cfgLevel), .cfgVector(cfgVector),
    .cfgDest(cfgDest), .eoiValid(eoiValid), .eoiVector(eoiVector),
    .reqValid(reqValid), .reqPin(reqPin), .reqVector(reqVector),
    .reqDest(reqDest), .reqAck(reqAck), .remoteIrr(remoteIrr),
    .rtcIrr(rtcIrr), .deliveryPending(deliveryPending)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!summaryDone) begin
      summaryDone = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    end
  endtask

  task automatic resetDut();
    rstN = 1'b0; lineIn = '0; cfgMask = '0; cfgPolarity = '0; cfgLevel = '0;
    cfgVector = '0; cfgDest = '0; eoiValid = 1'b0; eoiVector = '0; reqAck = 1'b0;
    tick(); tick();
    rstN = 1'b1;
    tick();
  endtask

  task automatic setPin(input int p, input bit lvl, input bit pol, input bit msk,
                        input logic [VW-1:0] v, input logic [DW-1:0] d);
    cfgLevel[p] = lvl; cfgPolarity[p] = pol; cfgMask[p] = msk;
    cfgVector[p*VW +: VW] = v; cfgDest[p*DW +: DW] = d;
  endtask

  task automatic sendEoi(input logic [VW-1:0] v);
    eoiVector = v; eoiValid = 1'b1;
    tick();
    eoiValid = 1'b0;
  endtask

  // Wait for a request, check its fields, then acknowledge it.
  task automatic expectReq(input int p, input logic [VW-1:0] v, input logic [DW-1:0] d,
                           input string tag);
    for (int n = 0; n < 8 && !reqValid; n++) tick();
    check(reqValid === 1'b1, {tag, " reqValid"}, reqValid, 1);
    if (reqValid) begin
      check(reqPin == PW'(p) && reqVector == v && reqDest == d, {tag, " pin/vector/dest"},
            {reqPin, reqVector, reqDest}, {PW'(p), v, d});
      reqAck = 1'b1;
      tick();
      reqAck = 1'b0;
    end
  endtask

  task automatic expectNone(input int n, input string tag);
    bit seen = 0;
    for (int k = 0; k < n; k++) begin
      tick();
      if (reqValid) seen = 1;
    end
    check(!seen, {tag, " no request"}, seen, 0);
  endtask

  function automatic logic [VW-1:0] rndVec(input int p);
    return VW'(8'h20 + (p % 4));
  endfunction

  initial begin
    #(200000 * 4);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [NP-1:0] modelIrr;
    int seed;
    seed = $urandom(32'h5eed);

    // Reset state
    resetDut();
    check(reqValid == 0 && remoteIrr == 0 && deliveryPending == 0 && rtcIrr == 0,
          "R10 reset state", {reqValid, remoteIrr, deliveryPending}, 0);

    // R1: edge fires once; EOI does not re-arm
    setPin(23, 0, 0, 0, 8'h3a, 8'h5f);
    lineIn[23] = 1'b1;
    expectReq(23, 8'h3a, 8'h5f, "R1 edge");
    expectNone(6, "R1 held");
    sendEoi(8'h3a);
    expectNone(6, "R1 after EOI");
    lineIn[23] = 1'b0; tick(); lineIn[23] = 1'b1;
    expectReq(23, 8'h3a, 8'h5f, "R1 second edge");

    // R2: masked edge dropped; unmask with line high is quiet
    lineIn[23] = 1'b0; cfgMask[23] = 1'b1; tick();
    lineIn[23] = 1'b1; tick(); lineIn[23] = 1'b0; tick(); lineIn[23] = 1'b1;
    expectNone(4, "R2 masked");
    cfgMask[23] = 1'b0;
    expectNone(6, "R2 unmask high");
    lineIn[23] = 1'b0; tick(); lineIn[23] = 1'b1;
    expectReq(23, 8'h3a, 8'h5f, "R2 fresh edge");

    // R4/R5: level coalescing and re-injection
    resetDut();
    setPin(5, 1, 0, 0, 8'h41, 8'h07);
    lineIn[5] = 1'b1;
    expectReq(5, 8'h41, 8'h07, "R4 level");
    check(remoteIrr[5] == 1'b1, "R4 irr set", remoteIrr[5], 1);
    expectNone(6, "R4 coalesce");
    sendEoi(8'h42);
    expectNone(3, "R5 other vector");
    check(remoteIrr[5] == 1'b1, "R5 other vector irr", remoteIrr[5], 1);
    sendEoi(8'h41);
    expectReq(5, 8'h41, 8'h07, "R5 reinject");
    lineIn[5] = 1'b0; tick();
    sendEoi(8'h41);
    check(remoteIrr[5] == 1'b0, "R5 irr cleared", remoteIrr[5], 0);
    expectNone(4, "R5 line low");

    // R3: level asserted while masked fires on unmask
    resetDut();
    setPin(12, 1, 0, 1, 8'h50, 8'h12);
    lineIn[12] = 1'b1;
    expectNone(5, "R3 masked");
    cfgMask[12] = 1'b0;
    expectReq(12, 8'h50, 8'h12, "R3 unmask");

    // R6: active-low level line
    resetDut();
    setPin(6, 1, 1, 0, 8'h60, 8'h06);
    expectReq(6, 8'h60, 8'h06, "R6 low asserts");
    lineIn[6] = 1'b1; tick();
    sendEoi(8'h60);
    expectNone(5, "R6 high inactive");
    check(remoteIrr[6] == 1'b0, "R6 irr", remoteIrr[6], 0);

    // R9: lowest pin first
    resetDut();
    setPin(3, 1, 0, 0, 8'h70, 8'h03);
    setPin(10, 1, 0, 0, 8'h71, 8'h0a);
    lineIn[3] = 1'b1; lineIn[10] = 1'b1;
    expectReq(3, 8'h70, 8'h03, "R9 first");
    expectReq(10, 8'h71, 8'h0a, "R9 second");

    // R8/R10: request holds while not acknowledged
    resetDut();
    setPin(15, 1, 0, 0, 8'h15, 8'h99);
    lineIn[15] = 1'b1;
    for (int n = 0; n < 8 && !reqValid; n++) tick();
    for (int k = 0; k < 5; k++) begin
      lineIn[15] = k[0];
      tick();
      check(reqValid && reqPin == 15 && reqVector == 8'h15 && reqDest == 8'h99,
            "R8 hold", {reqValid, reqPin, reqVector, reqDest}, {1'b1, 5'd15, 8'h15, 8'h99});
      check(deliveryPending == NP'(1) << 15, "R10 pending", deliveryPending, NP'(1) << 15);
    end
    lineIn[15] = 1'b1;
    expectReq(15, 8'h15, 8'h99, "R8 ack");
    tick();
    check(deliveryPending == 0, "R10 idle", deliveryPending, 0);

    // R7: RTC pin edge coalescing
    resetDut();
    setPin(8, 0, 0, 0, 8'h28, 8'h08);
    lineIn[8] = 1'b1;
    expectReq(8, 8'h28, 8'h08, "R7 first");
    check(rtcIrr == 1'b1, "R7 flag set", rtcIrr, 1);
    lineIn[8] = 1'b0; tick(); lineIn[8] = 1'b1;
    expectNone(5, "R7 coalesced");
    sendEoi(8'h28);
    check(rtcIrr == 1'b0, "R7 flag cleared", rtcIrr, 0);
    lineIn[8] = 1'b0; tick(); lineIn[8] = 1'b1;
    expectReq(8, 8'h28, 8'h08, "R7 after EOI");

    // R11: switch to edge clears flag; back to level acts as EOI
    resetDut();
    setPin(4, 1, 0, 0, 8'h44, 8'h04);
    lineIn[4] = 1'b1;
    expectReq(4, 8'h44, 8'h04, "R11 level");
    cfgLevel[4] = 1'b0; tick(); tick();
    check(remoteIrr[4] == 1'b0, "R11 edge clears", remoteIrr[4], 0);
    cfgLevel[4] = 1'b1;
    expectReq(4, 8'h44, 8'h04, "R11 implicit EOI");

    // Random phase: all level pins, four shared vectors (R4, R5, R8)
    resetDut();
    for (int p = 0; p < NP; p++) setPin(p, 1, 0, 0, rndVec(p), DW'(p));
    modelIrr = '0;
    for (int it = 0; it < 3000; it++) begin
      bit ackNow;
      bit eoiNow;
      logic [VW-1:0] ev;
      tick();
      check(remoteIrr == modelIrr, "R5 random irr", remoteIrr, modelIrr);
      ackNow = 1'b0;
      if (reqValid) begin
        check(reqVector == rndVec(int'(reqPin)) && reqDest == DW'(reqPin)
              && !modelIrr[reqPin], "R4 random req",
              {reqVector, reqDest}, {rndVec(int'(reqPin)), DW'(reqPin)});
        ackNow = ($urandom % 3) == 0;
      end
      eoiNow = ($urandom % 5) == 0;
      ev = rndVec(int'($urandom % 4));
      for (int p = 0; p < NP; p++) if (($urandom % 10) == 0) lineIn[p] = ~lineIn[p];
      if (eoiNow)
        for (int p = 0; p < NP; p++) if (rndVec(p) == ev) modelIrr[p] = 1'b0;
      if (ackNow) modelIrr[reqPin] = 1'b1;
      reqAck = ackNow; eoiValid = eoiNow; eoiVector = ev;
    end
    tick();
    check(remoteIrr == modelIrr, "R5 random final", remoteIrr, modelIrr);
    reqAck = 1'b0; eoiValid = 1'b0;

    summary();
    $finish;
  end
endmodule